// File: doc/BRIEF.md
# Level Control Step Pacer

This block paces the gain moves of an automatic level control loop that drives a programmable input amplifier. It does not detect level and does not apply gain. It watches two level flags from an upstream detector and issues single-cycle requests that tell a downstream gain stage to move one step down or one step up. All time is counted in sample strobes, so the pacing follows the sample rate and not the system clock.

Attenuation is fast. The first down request comes on the first strobe where the signal is above the limiter threshold. While the overload lasts, further down requests repeat at a selectable limiter period.

Recovery is slow. A wait counter advances on each strobe where the level is below the recovery reset level and no limiting is going on. Any strobe with the level above that reset level clears the counter, and so does any strobe with limiting. When the counter reaches the selected wait period, an up request is issued and the count starts again. A rate select bit picks between period sets for a 32 kHz sample rate and a 48 kHz sample rate.

Top module: `alc_step_timer`

## Requirements
- R1: While rst_ni is low, down_o and up_o are 0 and all counters clear. After release, no request comes before the first strobe.
- R2: A down request is issued on the first strobe where above_lim_i is 1 and the previous strobe was not limiting. This includes a new overload after a release.
- R3: While above_lim_i stays 1 on successive strobes, down requests repeat every P strobes. At rate_sel_i=0, P is 2, 4, 8 or 16 for lim_sel_i = 00, 01, 10 or 11.
- R4: At rate_sel_i=1, the limiter period P is 3, 6, 12 or 24 for lim_sel_i = 00, 01, 10 or 11.
- R5: An up request is issued on the W-th consecutive strobe with above_lim_i=0 and above_rst_i=0, and then again every W strobes. At rate_sel_i=0, W is 256, 512, 2048 or 16384 for wait_sel_i = 00, 01, 10 or 11. At rate_sel_i=1, W is 384, 768, 3072 or 24576.
- R6: Any strobe with above_rst_i=1 clears the recovery wait count, and counting starts again from zero.
- R7: Any strobe with above_lim_i=1 clears the recovery wait count. down_o and up_o are never 1 in the same cycle.
- R8: Clock cycles without strobe_i neither advance nor clear any count.
- R9: If a select change makes a running count reach or pass its new period, the next qualifying strobe issues the request.
- R10: Each request is a one-cycle pulse. It appears in the clock cycle after the edge that sampled the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle sample strobe |
| above_lim_i | input | 1 | Level is above the limiter threshold |
| above_rst_i | input | 1 | Level is above the recovery reset level |
| lim_sel_i | input | 2 | Limiter period select |
| wait_sel_i | input | 2 | Recovery wait select |
| rate_sel_i | input | 1 | 0: 32 kHz period set, 1: 48 kHz period set |
| down_o | output | 1 | Step gain down request |
| up_o | output | 1 | Step gain up request |

## Verification
Each request is registered once. A pulse is therefore visible in the cycle after the clock edge that took in its strobe, and the bench reads both outputs one time unit after that edge. Each scenario task drives one strobe per call and records the index of that strobe. The expected firing index (strobe 1, P+1, 2P+1 for the limiter, and strobe W, 2W for recovery) is then compared with the exact strobe that produced each pulse. Strobe-free gaps check that idle cycles shift none of these indices.

// File: rtl/alc_timer_pkg.sv
package alc_timer_pkg;

  // recovery multiplier as a left shift: x1, x2, x8, x64
  function automatic int unsigned rec_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 1;
      2'd2:    return 3;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/alc_period_map.sv
module alc_period_map #(
  parameter int unsigned LIM_BASE_LO = 2,
  parameter int unsigned LIM_BASE_HI = 3,
  parameter int unsigned REC_BASE_LO = 256,
  parameter int unsigned REC_BASE_HI = 384,
  parameter int unsigned LIM_W       = 5,
  parameter int unsigned REC_W       = 15
) (
  input  logic [1:0]       lim_sel_i,
  input  logic [1:0]       wait_sel_i,
  input  logic             rate_sel_i,
  output logic [LIM_W-1:0] lim_period_o,
  output logic [REC_W-1:0] rec_period_o
);
  import alc_timer_pkg::*;

  logic [LIM_W-1:0] lim_base;
  logic [REC_W-1:0] rec_base;

  always_comb begin
    lim_base     = rate_sel_i ? LIM_W'(LIM_BASE_HI) : LIM_W'(LIM_BASE_LO);
    rec_base     = rate_sel_i ? REC_W'(REC_BASE_HI) : REC_W'(REC_BASE_LO);
    lim_period_o = lim_base << lim_sel_i;
    rec_period_o = rec_base << rec_shift(wait_sel_i);
  end

endmodule

// File: rtl/alc_step_pacer.sv
module alc_step_pacer #(
  parameter int unsigned CNT_W     = 8,
  parameter bit          FIRST_NOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             fire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             due;
  logic             first;

  generate
    if (FIRST_NOW) begin : g_first
      logic active_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     active_q <= 1'b0;
        else if (tick_i) active_q <= hold_i;
      end
      assign first = !active_q;
    end else begin : g_wait
      assign first = 1'b0;
    end
  endgenerate

  // >= so a shortened period takes effect at once
  assign due = first || (cnt_q >= period_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (tick_i) begin
        if (!hold_i) begin
          cnt_q <= '0;
        end else if (due) begin
          cnt_q  <= '0;
          fire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assert_fire_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(tick_i && hold_i));
  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  assert_idle_keeps_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/alc_step_timer.sv
module alc_step_timer #(
  parameter int unsigned LIM_BASE_LO = 2,
  parameter int unsigned LIM_BASE_HI = 3,
  parameter int unsigned REC_BASE_LO = 256,
  parameter int unsigned REC_BASE_HI = 384
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic       above_lim_i,
  input  logic       above_rst_i,
  input  logic [1:0] lim_sel_i,
  input  logic [1:0] wait_sel_i,
  input  logic       rate_sel_i,
  output logic       down_o,
  output logic       up_o
);

  localparam int unsigned LIM_MAX = ((LIM_BASE_HI > LIM_BASE_LO) ? LIM_BASE_HI : LIM_BASE_LO) << 3;
  localparam int unsigned REC_MAX = ((REC_BASE_HI > REC_BASE_LO) ? REC_BASE_HI : REC_BASE_LO) << 6;
  localparam int unsigned LIM_W   = $clog2(LIM_MAX + 1);
  localparam int unsigned REC_W   = $clog2(REC_MAX + 1);

  logic [LIM_W-1:0] lim_period;
  logic [REC_W-1:0] rec_period;
  logic             rec_hold;

  alc_period_map #(
    .LIM_BASE_LO(LIM_BASE_LO), .LIM_BASE_HI(LIM_BASE_HI),
    .REC_BASE_LO(REC_BASE_LO), .REC_BASE_HI(REC_BASE_HI),
    .LIM_W(LIM_W), .REC_W(REC_W)
  ) i_map (
    .lim_sel_i   (lim_sel_i),
    .wait_sel_i  (wait_sel_i),
    .rate_sel_i  (rate_sel_i),
    .lim_period_o(lim_period),
    .rec_period_o(rec_period)
  );

  alc_step_pacer #(.CNT_W(LIM_W), .FIRST_NOW(1'b1)) i_lim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (strobe_i),
    .hold_i  (above_lim_i),
    .period_i(lim_period),
    .fire_o  (down_o)
  );

  // limiting or a level above the reset level both restart the wait
  assign rec_hold = !(above_lim_i || above_rst_i);

  alc_step_pacer #(.CNT_W(REC_W), .FIRST_NOW(1'b0)) i_rec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (strobe_i),
    .hold_i  (rec_hold),
    .period_i(rec_period),
    .fire_o  (up_o)
  );

  assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(down_o && up_o));
  assert_up_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |-> $past(!above_lim_i && !above_rst_i));
  assert_down_on_over_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_o |-> $past(above_lim_i && strobe_i));
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!down_o && !up_o));

endmodule

// File: tb/test_alc_step_timer.sv
module test_alc_step_timer;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strobe_i = 1'b0;
  logic       above_lim_i = 1'b0;
  logic       above_rst_i = 1'b0;
  logic [1:0] lim_sel_i = 2'b01;
  logic [1:0] wait_sel_i = 2'b00;
  logic       rate_sel_i = 1'b0;
  logic       down_o, up_o;

  int n_run = 0;
  int n_fail = 0;
  logic d, u;

  always #4 clk_i = ~clk_i;

  alc_step_timer i_alc_step_timer (
    .clk_i, .rst_ni, .strobe_i, .above_lim_i, .above_rst_i,
    .lim_sel_i, .wait_sel_i, .rate_sel_i, .down_o, .up_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic lim, input logic rst, input logic stb = 1'b1);
    @(negedge clk_i);
    above_lim_i = lim;
    above_rst_i = rst;
    strobe_i    = stb;
    @(posedge clk_i);
    #1;
    d = down_o;
    u = up_o;
  endtask

  // calm strobes so no limiter state is carried in
  task automatic settle();
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(down_o == 0 && up_o == 0, "R1 outputs in reset", {down_o, up_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick(1'b1, 1'b1, 1'b0);
    tick(1'b1, 1'b1, 1'b0);
    chk(d == 0 && u == 0, "R1 no request without strobe", {d, u}, 0);
  endtask

  task automatic t_lim_default();
    int bad = 0;
    int nd  = 0;
    lim_sel_i  = 2'b01;
    rate_sel_i = 1'b0;
    settle();
    for (int i = 0; i < 13; i++) begin
      tick(1'b1, 1'b1);
      if (d != ((i % 4) == 0)) bad++;
      if (d) nd++;
      if (i == 0) chk(d == 1, "R2 immediate down", d, 1);
    end
    chk(bad == 0 && nd == 4, "R3 period 4 at 32k/01", nd, 4);
    tick(1'b0, 1'b1);
    chk(d == 0, "R2 no down when released", d, 0);
    tick(1'b1, 1'b1);
    chk(d == 1, "R2 re-cross immediate", d, 1);
  endtask

  task automatic t_lim_all();
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < 4; s++) begin
        int first = -1;
        int second = -1;
        int exp;
        rate_sel_i = r[0];
        lim_sel_i  = s[1:0];
        exp = (r == 0 ? 2 : 3) << s;
        settle();
        for (int i = 0; i < 2 * exp + 1; i++) begin
          tick(1'b1, 1'b1);
          if (d && first < 0) first = i;
          else if (d && second < 0) second = i;
        end
        if (r == 0) chk(first == 0 && second - first == exp, "R3 limiter spacing", second - first, exp);
        else        chk(first == 0 && second - first == exp, "R4 limiter spacing", second - first, exp);
      end
    end
  endtask

  // run n quiet strobes, return index of first up and number of ups
  task automatic quiet_run(input int n, output int first, output int cnt, output int bad_down);
    first = -1; cnt = 0; bad_down = 0;
    for (int i = 0; i < n; i++) begin
      tick(1'b0, 1'b0);
      if (u) begin
        if (first < 0) first = i;
        cnt++;
      end
      if (d) bad_down++;
    end
  endtask

  task automatic t_recover();
    int f, c, bd;
    wait_sel_i = 2'b00;
    rate_sel_i = 1'b0;
    settle();
    quiet_run(600, f, c, bd);
    chk(f == 255 && c == 2, "R5 up every 256 at 32k/00", f, 255);
    chk(bd == 0, "R7 no down while quiet", bd, 0);
    wait_sel_i = 2'b01;
    rate_sel_i = 1'b1;
    settle();
    quiet_run(800, f, c, bd);
    chk(f == 767 && c == 1, "R5 up at 768 at 48k/01", f, 767);
  endtask

  task automatic t_rst_level();
    int f, c, bd;
    wait_sel_i = 2'b00;
    rate_sel_i = 1'b0;
    settle();
    quiet_run(200, f, c, bd);
    chk(c == 0, "R6 no early up", c, 0);
    tick(1'b0, 1'b1);
    chk(u == 0, "R6 no up on reset level", u, 0);
    quiet_run(260, f, c, bd);
    chk(f == 255, "R6 wait restarts", f, 255);
  endtask

  task automatic t_lim_clears();
    int f, c, bd;
    lim_sel_i  = 2'b01;
    wait_sel_i = 2'b00;
    rate_sel_i = 1'b0;
    settle();
    quiet_run(250, f, c, bd);
    tick(1'b1, 1'b0);
    chk(d == 1 && u == 0, "R7 limiter wins", {d, u}, 2);
    quiet_run(260, f, c, bd);
    chk(f == 255, "R7 limiter clears wait", f, 255);
  endtask

  task automatic t_gaps();
    int f, c, bd;
    lim_sel_i  = 2'b01;
    rate_sel_i = 1'b0;
    settle();
    tick(1'b1, 1'b1);
    chk(d == 1, "R8 first down", d, 1);
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b1);
    c = 0;
    for (int i = 0; i < 10; i++) begin
      tick(1'b1, 1'b1, 1'b0);
      if (d) c++;
    end
    chk(c == 0, "R8 no down in idle cycles", c, 0);
    tick(1'b1, 1'b1);
    chk(d == 0, "R8 count held (strobe 4)", d, 0);
    tick(1'b1, 1'b1);
    chk(d == 1, "R8 down at strobe 5", d, 1);
    // quiet with gaps: 255 quiet strobes interleaved with idle cycles
    wait_sel_i = 2'b00;
    settle();
    c = 0;
    for (int i = 0; i < 255; i++) begin
      tick(1'b0, 1'b0);
      if (u) c++;
      tick(1'b0, 1'b1, 1'b0);
      if (u) c++;
    end
    chk(c == 0, "R8 idle cycles do not clear", c, 0);
    tick(1'b0, 1'b0);
    chk(u == 1, "R8 up at 256th strobe", u, 1);
    tick(1'b0, 1'b0);
    chk(u == 0, "R10 up is one cycle", u, 0);
  endtask

  task automatic t_sel_change();
    lim_sel_i  = 2'b11;
    rate_sel_i = 1'b0;
    settle();
    tick(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b1);
    chk(d == 0, "R9 no down before change", d, 0);
    lim_sel_i = 2'b00;
    tick(1'b1, 1'b1);
    chk(d == 1, "R9 shortened period fires", d, 1);
    tick(1'b1, 1'b1);
    chk(d == 0, "R10 down is one cycle", d, 0);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_lim_default();
    t_lim_all();
    t_recover();
    t_rst_level();
    t_lim_clears();
    t_gaps();
    t_sel_change();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule